// File: doc/BRIEF.md
# Serial Link Request Decoder

This block sits on the PHY side of a legacy PHY-to-link interface and turns the link's serial request line back into whole requests. The link shifts one bit per clock onto `ser_req`. The line rests at 0, and every request opens with a 1. The decoder collects the bits and finds where each request ends from its type field. For every complete request that is to be acted on, it presents the request type, a speed code normalized to three bits, any register address and data carried by the request, and a flag for speeds above S400. All of these appear together with a one-cycle valid strobe.

Bus requests come in two lengths. The short form is 7 bits and carries a 2-bit speed. The long form is 8 bits and carries a 3-bit speed. The decoder separates the two forms by the bit that follows the seventh. A 0 there is the long form's stop bit. A 1 there is the start of the next request, which the decoder then goes on to receive with no lost cycle. The 3-bit code for a speed is the 2-bit code with a 0 appended at the low end, so both forms give the same normalized speed for S100, S200 and S400. Requests that switch arbitration acceleration or multispeed concatenation are passed on only while the matching enable input is set. Driving `mode_new` high selects the newer interface format, and in that case this decoder stays idle.

Top module: `link_req_decoder`

## Requirements
- R1: A request is a 1 start bit followed by a 3-bit type, most significant bit first. Type codes: 000 fair bus request, 001 priority bus request, 010 register read, 011 register write, 100 acceleration control, 101 concatenation control, 110 and 111 reserved. Zeros on an idle line produce nothing.
- R2: Short bus request (7 bits): after the type come two speed bits s1,s0 and then a 0. It reports `req_speed` = {s1,s0,0}.
- R3: Long bus request (8 bits): after the type come three speed bits s2,s1,s0 and then a stop 0. It reports `req_speed` = {s2,s1,s0}.
- R4: If the bit after a short bus request's seventh bit is 1, that bit is the start of the next request. Both requests are decoded.
- R5: `req_over_s400` is set for a bus request whose speed is not 000 (S100), 010 (S200) or 100 (S400). For all other types `req_speed` and `req_over_s400` are zero.
- R6: A register read is 8 bits, with a 4-bit address after the type, most significant bit first, and `req_data` is zero. A register write is 16 bits, with the 4-bit address and then 8 data bits, each field most significant bit first.
- R7: Acceleration control (100) and concatenation control (101) are 5 bits, and their argument bit appears on `req_data[0]`. Each is reported only if `accel_en` (for 100) or `concat_en` (for 101) is high in the cycle that carries its last bit. Otherwise it gives no pulse, and the decoder is ready for a request that starts on the next bit.
- R8: Reserved types (110, 111) are 4 bits long. They are reported with all payload outputs zero.
- R9: `req_valid` is high for exactly one cycle, the cycle after the request's last bit is sampled (for a bus request, the bit after the seventh). While `req_valid` is low, all field outputs are zero.
- R10: While `mode_new` is high, no request is reported and any partly received request is dropped. Decoding starts afresh once it is low again.
- R11: Driving `rst_n` low clears `req_valid` and drops any partly received request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one request bit per rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with the clock |
| mode_new | input | 1 | High: newer interface format, decoder idle |
| ser_req | input | 1 | Serial request line from the link |
| accel_en | input | 1 | Allows acceleration control requests |
| concat_en | input | 1 | Allows concatenation control requests |
| req_valid | output | 1 | One-cycle strobe for a decoded request |
| req_type | output | 3 | Request type code |
| req_speed | output | 3 | Normalized bus request speed |
| req_over_s400 | output | 1 | Bus request speed above S400 |
| req_addr | output | 4 | Register address |
| req_data | output | 8 | Register write data or control argument |

## Verification
The bench goes after the short/long ambiguity from every side. It sends short requests followed by idle, by a new request's start bit, and by another short request. A decoder that read the eighth bit wrongly would drop or garble the following request, or report a short request's speed with a stray low bit. It also sends long requests whose speed ends in 1, so that a decoder treating the seventh bit as a stop bit would report the wrong speed or a wrong over-S400 flag. Disabled control requests are followed at once by another request, which shows that their length is still honoured. A reset or a mode change in the middle of a request checks that the leftover bits are dropped instead of being joined onto the next frame.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
  localparam int TYPE_W = 3;
  localparam int SPD_W  = 3;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int WORD_W = ADDR_W + DATA_W;

  // Bit index of the last bit of each frame kind (start bit is index 0).
  localparam int P_TYPE_END = TYPE_W;
  localparam int P_CTL_END  = TYPE_W + 1;
  localparam int P_BUS_END  = TYPE_W + SPD_W + 1;
  localparam int P_RD_END   = TYPE_W + ADDR_W;
  localparam int P_WR_END   = TYPE_W + ADDR_W + DATA_W;
  localparam int POS_W      = $clog2(P_WR_END + 1);

  typedef enum logic [TYPE_W-1:0] {
    RT_BUS_FAIR = 3'b000,
    RT_BUS_PRIO = 3'b001,
    RT_REG_RD   = 3'b010,
    RT_REG_WR   = 3'b011,
    RT_ACCEL    = 3'b100,
    RT_CONCAT   = 3'b101,
    RT_RSV_A    = 3'b110,
    RT_RSV_B    = 3'b111
  } req_type_e;

  typedef struct packed {
    logic [TYPE_W-1:0] rtype;
    logic [SPD_W-1:0]  speed;
    logic              over;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } req_fields_t;

  function automatic logic is_bus(input logic [TYPE_W-1:0] t);
    return t[TYPE_W-1:1] == '0;
  endfunction

  function automatic logic [POS_W-1:0] last_pos(input logic [TYPE_W-1:0] t);
    case (t)
      RT_BUS_FAIR, RT_BUS_PRIO: return POS_W'(P_BUS_END);
      RT_REG_RD:                return POS_W'(P_RD_END);
      RT_REG_WR:                return POS_W'(P_WR_END);
      RT_ACCEL, RT_CONCAT:      return POS_W'(P_CTL_END);
      default:                  return POS_W'(P_TYPE_END);
    endcase
  endfunction

  function automatic logic speed_over(input logic [SPD_W-1:0] s);
    return !((s == 3'b000) || (s == 3'b010) || (s == 3'b100));
  endfunction
endpackage

// File: rtl/lrd_frame_ctl.sv
module lrd_frame_ctl
  import lrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              line_in,
  output logic              done,
  output logic [TYPE_W-1:0] done_type,
  output logic [WORD_W-1:0] done_word
);
  logic              busy_q, busy_n;
  logic [POS_W-1:0]  pos_q, pos_n;
  logic [WORD_W-1:0] sreg_q, sreg_n;
  logic [TYPE_W-1:0] type_q, type_n;
  logic [WORD_W-1:0] cur_word;
  logic [TYPE_W-1:0] cur_type;
  logic              at_last;
  logic              ce;

  assign cur_word = {sreg_q[WORD_W-2:0], line_in};
  assign cur_type = (pos_q == POS_W'(P_TYPE_END)) ? cur_word[TYPE_W-1:0] : type_q;
  assign at_last  = busy_q && (pos_q == last_pos(cur_type));
  assign ce       = !enable || busy_q || line_in;

  always_comb begin
    busy_n = busy_q;
    pos_n  = pos_q;
    sreg_n = sreg_q;
    type_n = type_q;
    if (!enable) begin
      busy_n = 1'b0;
    end else if (!busy_q) begin
      if (line_in) begin
        busy_n = 1'b1;
        pos_n  = POS_W'(1);
        sreg_n = '0;
      end
    end else begin
      sreg_n = cur_word;
      if (pos_q == POS_W'(P_TYPE_END)) type_n = cur_type;
      if (at_last) begin
        // A 1 after a short bus request is the next start bit.
        if (is_bus(cur_type) && line_in) begin
          busy_n = 1'b1;
          pos_n  = POS_W'(1);
          sreg_n = '0;
        end else begin
          busy_n = 1'b0;
        end
      end else begin
        pos_n = pos_q + POS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      sreg_q <= '0;
      type_q <= '0;
    end else if (ce) begin
      busy_q <= busy_n;
      pos_q  <= pos_n;
      sreg_q <= sreg_n;
      type_q <= type_n;
    end
  end

  assign done      = enable && at_last;
  assign done_type = cur_type;
  assign done_word = cur_word;
endmodule

// File: rtl/lrd_field_unpack.sv
module lrd_field_unpack
  import lrd_pkg::*;
(
  input  logic [TYPE_W-1:0] rtype,
  input  logic [WORD_W-1:0] word,
  input  logic              accel_en,
  input  logic              concat_en,
  output req_fields_t       fields,
  output logic              keep
);
  always_comb begin
    fields       = '0;
    fields.rtype = rtype;
    keep         = 1'b1;
    case (rtype)
      RT_BUS_FAIR, RT_BUS_PRIO: begin
        fields.speed = word[SPD_W:1];
        fields.over  = speed_over(word[SPD_W:1]);
      end
      RT_REG_RD: fields.addr = word[ADDR_W-1:0];
      RT_REG_WR: begin
        fields.addr = word[WORD_W-1:DATA_W];
        fields.data = word[DATA_W-1:0];
      end
      RT_ACCEL: begin
        fields.data = DATA_W'(word[0]);
        keep        = accel_en;
      end
      RT_CONCAT: begin
        fields.data = DATA_W'(word[0]);
        keep        = concat_en;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/link_req_decoder.sv
module link_req_decoder
  import lrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_new,
  input  logic              ser_req,
  input  logic              accel_en,
  input  logic              concat_en,
  output logic              req_valid,
  output logic [TYPE_W-1:0] req_type,
  output logic [SPD_W-1:0]  req_speed,
  output logic              req_over_s400,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);
  logic              done;
  logic [TYPE_W-1:0] done_type;
  logic [WORD_W-1:0] done_word;
  req_fields_t       fields;
  logic              keep;
  logic              valid_n, valid_q;
  req_fields_t       out_n, out_q;

  lrd_frame_ctl u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (!mode_new),
    .line_in   (ser_req),
    .done      (done),
    .done_type (done_type),
    .done_word (done_word)
  );

  lrd_field_unpack u_unpack (
    .rtype     (done_type),
    .word      (done_word),
    .accel_en  (accel_en),
    .concat_en (concat_en),
    .fields    (fields),
    .keep      (keep)
  );

  always_comb begin
    valid_n = done && keep;
    out_n   = valid_n ? fields : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      out_q   <= '0;
    end else begin
      valid_q <= valid_n;
      out_q   <= out_n;
    end
  end

  assign req_valid     = valid_q;
  assign req_type      = out_q.rtype;
  assign req_speed     = out_q.speed;
  assign req_over_s400 = out_q.over;
  assign req_addr      = out_q.addr;
  assign req_data      = out_q.data;
endmodule

// File: rtl/lrd_checker.sv
module lrd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_new,
  input logic       accel_en,
  input logic       concat_en,
  input logic       req_valid,
  input logic [2:0] req_type,
  input logic [2:0] req_speed,
  input logic       req_over_s400,
  input logic [3:0] req_addr,
  input logic [7:0] req_data
);
  assert_mode_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_new |=> !req_valid);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (req_type == 3'b0 && req_speed == 3'b0 && !req_over_s400
                    && req_addr == 4'b0 && req_data == 8'b0));

  assert_over_bus_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_over_s400) |-> (req_type[2:1] == 2'b00));

  assert_nonbus_speed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type[2:1] != 2'b00) |-> (req_speed == 3'b0 && !req_over_s400));

  assert_accel_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 3'b100) |-> $past(accel_en));

  assert_concat_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 3'b101) |-> $past(concat_en));
endmodule

bind link_req_decoder lrd_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_new      (mode_new),
  .accel_en      (accel_en),
  .concat_en     (concat_en),
  .req_valid     (req_valid),
  .req_type      (req_type),
  .req_speed     (req_speed),
  .req_over_s400 (req_over_s400),
  .req_addr      (req_addr),
  .req_data      (req_data)
);

// File: tb/link_req_decoder_test.sv
module link_req_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 8000;
  localparam int MAXE = 1200;

  logic clk, rst_n, mode_new, ser_req, accel_en, concat_en;
  logic req_valid, req_over_s400;
  logic [2:0] req_type, req_speed;
  logic [3:0] req_addr;
  logic [7:0] req_data;

  link_req_decoder uut (
    .clk(clk), .rst_n(rst_n), .mode_new(mode_new), .ser_req(ser_req),
    .accel_en(accel_en), .concat_en(concat_en), .req_valid(req_valid),
    .req_type(req_type), .req_speed(req_speed), .req_over_s400(req_over_s400),
    .req_addr(req_addr), .req_data(req_data)
  );

  // Stimulus script, one entry per clock
  logic b_line [MAXB];
  logic b_rst  [MAXB];
  logic b_mode [MAXB];
  logic b_aen  [MAXB];
  logic b_cen  [MAXB];
  int   nb;
  logic cur_rst, cur_mode, cur_aen, cur_cen;

  // Expected reports
  int         e_idx  [MAXE];
  logic [2:0] e_type [MAXE];
  logic [2:0] e_spd  [MAXE];
  logic       e_over [MAXE];
  logic [3:0] e_addr [MAXE];
  logic [7:0] e_data [MAXE];
  string      e_tag  [MAXE];
  int         ne, ep;

  int tests, fails;
  bit finished;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function void push(input logic v);
    b_line[nb] = v; b_rst[nb] = cur_rst; b_mode[nb] = cur_mode;
    b_aen[nb] = cur_aen; b_cen[nb] = cur_cen;
    nb++;
  endfunction

  function void push_bits(input logic [15:0] v, input int n);
    for (int k = n - 1; k >= 0; k--) push(v[k]);
  endfunction

  function void idle(input int n);
    for (int k = 0; k < n; k++) push(1'b0);
  endfunction

  function logic over_of(input logic [2:0] s);
    return !(s == 3'b000 || s == 3'b010 || s == 3'b100);
  endfunction

  function void expect_req(input int idx, input logic [2:0] t, input logic [2:0] s,
                           input logic o, input logic [3:0] a, input logic [7:0] d,
                           input string tag);
    if (cur_mode || !cur_rst) return;
    e_idx[ne] = idx; e_type[ne] = t; e_spd[ne] = s; e_over[ne] = o;
    e_addr[ne] = a; e_data[ne] = d; e_tag[ne] = tag;
    ne++;
  endfunction

  // R2 / R3: short form uses spd[2:1] only, long form all three bits
  function void add_bus(input logic [2:0] t, input logic [2:0] spd, input logic lng,
                        input string tag);
    int s;
    logic [2:0] nspd;
    s = nb;
    push(1'b1);
    push_bits(16'(t), 3);
    if (lng) begin
      push_bits(16'(spd), 3); push(1'b0); nspd = spd;
    end else begin
      push_bits(16'(spd[2:1]), 2); push(1'b0); nspd = {spd[2:1], 1'b0};
    end
    expect_req(s + 7, t, nspd, over_of(nspd), 4'h0, 8'h00, tag);
  endfunction

  function void add_rd(input logic [3:0] a);
    int s;
    s = nb;
    push(1'b1); push_bits(16'(3'b010), 3); push_bits(16'(a), 4);
    expect_req(s + 7, 3'b010, 3'b000, 1'b0, a, 8'h00, "R6");
  endfunction

  function void add_wr(input logic [3:0] a, input logic [7:0] d);
    int s;
    s = nb;
    push(1'b1); push_bits(16'(3'b011), 3); push_bits(16'(a), 4); push_bits(16'(d), 8);
    expect_req(s + 15, 3'b011, 3'b000, 1'b0, a, d, "R6");
  endfunction

  function void add_ctl(input logic [2:0] t, input logic arg);
    int s;
    logic en;
    s = nb;
    push(1'b1); push_bits(16'(t), 3); push(arg);
    en = (t == 3'b100) ? cur_aen : cur_cen;
    if (en) expect_req(s + 4, t, 3'b000, 1'b0, 4'h0, {7'b0, arg}, "R7");
  endfunction

  function void add_rsv(input logic [2:0] t);
    int s;
    s = nb;
    push(1'b1); push_bits(16'(t), 3);
    expect_req(s + 3, t, 3'b000, 1'b0, 4'h0, 8'h00, "R8");
  endfunction

  task automatic check_cycle(input int c);
    string utag;
    if (ep < ne && e_idx[ep] == c) begin
      tests++;
      if (!req_valid) begin
        fails++;
        $display("FAIL %s: cycle %0d valid=0 expected=1 (type %b)", e_tag[ep], c, e_type[ep]);
      end else if (req_type !== e_type[ep] || req_speed !== e_spd[ep] ||
                   req_over_s400 !== e_over[ep] || req_addr !== e_addr[ep] ||
                   req_data !== e_data[ep]) begin
        fails++;
        $display("FAIL %s: cycle %0d got t=%b s=%b o=%b a=%h d=%h expected t=%b s=%b o=%b a=%h d=%h",
                 e_tag[ep], c, req_type, req_speed, req_over_s400, req_addr, req_data,
                 e_type[ep], e_spd[ep], e_over[ep], e_addr[ep], e_data[ep]);
      end
      ep++;
    end else begin
      tests++;
      utag = !b_rst[c] ? "R11" : (b_mode[c] ? "R10" : "R9");
      if (req_valid) begin
        fails++;
        $display("FAIL %s: cycle %0d unexpected valid=1 expected=0 (type %b)", utag, c, req_type);
      end else if (req_type != 0 || req_speed != 0 || req_over_s400 || req_addr != 0 || req_data != 0) begin
        fails++;
        $display("FAIL R9: cycle %0d idle fields t=%b s=%b o=%b a=%h d=%h expected all zero",
                 c, req_type, req_speed, req_over_s400, req_addr, req_data);
      end
    end
  endtask

  task automatic build();
    int unsigned seed;
    logic [2:0] t, sp;
    logic lng;
    seed = $urandom(32'd24681357);
    nb = 0; ne = 0;
    cur_rst = 1'b0; cur_mode = 1'b0; cur_aen = 1'b1; cur_cen = 1'b1;
    idle(3);                                 // R11 reset state
    cur_rst = 1'b1;
    idle(3);                                 // R1 idle line, no report
    // R2 short forms, then idle
    add_bus(3'b000, 3'b000, 1'b0, "R2"); idle(2);
    add_bus(3'b001, 3'b010, 1'b0, "R2"); idle(1);
    add_bus(3'b000, 3'b100, 1'b0, "R2"); idle(2);
    add_bus(3'b001, 3'b110, 1'b0, "R5"); idle(2);   // 2-bit 11 -> over
    // R3 long forms, including odd low speed bit
    add_bus(3'b000, 3'b000, 1'b1, "R3"); idle(1);
    add_bus(3'b000, 3'b010, 1'b1, "R3"); idle(1);
    add_bus(3'b001, 3'b100, 1'b1, "R3"); idle(1);
    add_bus(3'b000, 3'b001, 1'b1, "R5"); idle(1);
    add_bus(3'b001, 3'b011, 1'b1, "R5"); idle(1);
    add_bus(3'b000, 3'b101, 1'b1, "R5"); idle(1);
    add_bus(3'b001, 3'b111, 1'b1, "R5"); idle(2);
    // R4 back-to-back after a short request
    add_bus(3'b000, 3'b010, 1'b0, "R4"); add_wr(4'hA, 8'h5C);
    add_bus(3'b001, 3'b100, 1'b0, "R4"); add_bus(3'b000, 3'b110, 1'b0, "R4");
    add_bus(3'b000, 3'b000, 1'b0, "R4"); add_bus(3'b001, 3'b011, 1'b1, "R4");
    add_rd(4'h3); add_rd(4'hC); idle(2);
    // R6 register requests
    add_wr(4'hF, 8'hFF); add_wr(4'h0, 8'h81); idle(1);
    // R7 control gating
    cur_aen = 1'b1; add_ctl(3'b100, 1'b1); add_ctl(3'b100, 1'b0);
    cur_aen = 1'b0; add_ctl(3'b100, 1'b1); add_rd(4'h9);
    cur_cen = 1'b1; add_ctl(3'b101, 1'b1);
    cur_cen = 1'b0; add_ctl(3'b101, 1'b1); add_bus(3'b000, 3'b100, 1'b1, "R7");
    cur_aen = 1'b1; cur_cen = 1'b1; idle(2);
    // R8 reserved
    add_rsv(3'b110); add_rsv(3'b111); add_rd(4'h5); idle(2);
    // R10 mode high: whole request ignored, then partial dropped
    cur_mode = 1'b1; idle(1); add_wr(4'h7, 8'h3C); add_bus(3'b000, 3'b010, 1'b1, "R10"); idle(2);
    cur_mode = 1'b0; idle(1);
    push(1'b1); push(1'b0); push(1'b1); push(1'b1); push(1'b0);
    cur_mode = 1'b1; idle(2); cur_mode = 1'b0; idle(1);
    add_bus(3'b001, 3'b010, 1'b1, "R10"); idle(2);
    // R11 reset in mid request
    push(1'b1); push(1'b0); push(1'b1); push(1'b1); push(1'b1);
    cur_rst = 1'b0; idle(2); cur_rst = 1'b1; idle(1);
    add_rd(4'hE); idle(2);
    // Random mix
    for (int k = 0; k < 300; k++) begin
      t = 3'($urandom % 8);
      case (t)
        3'b000, 3'b001: begin
          lng = 1'($urandom % 2);
          sp  = lng ? 3'($urandom % 8) : {2'($urandom % 4), 1'b0};
          add_bus(t, sp, lng, lng ? "R3" : "R4");
        end
        3'b010: add_rd(4'($urandom % 16));
        3'b011: add_wr(4'($urandom % 16), 8'($urandom % 256));
        3'b100, 3'b101: begin
          cur_aen = 1'($urandom % 2); cur_cen = 1'($urandom % 2);
          add_ctl(t, 1'($urandom % 2));
        end
        default: add_rsv(t);
      endcase
      idle(int'($urandom % 3));
    end
    idle(4);
  endtask

  initial begin
    tests = 0; fails = 0; ep = 0; finished = 0;
    rst_n = 1'b0; mode_new = 1'b0; ser_req = 1'b0; accel_en = 1'b0; concat_en = 1'b0;
    build();
    for (int i = 0; i <= nb; i++) begin
      @(negedge clk);
      if (i > 0) check_cycle(i - 1);
      if (i < nb) begin
        ser_req = b_line[i]; rst_n = b_rst[i]; mode_new = b_mode[i];
        accel_en = b_aen[i]; concat_en = b_cen[i];
      end
    end
    tests++;
    if (ep != ne) begin
      fails++;
      $display("FAIL R9: reports matched %0d expected %0d", ep, ne);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL R9: watchdog expired, matched %0d expected %0d", ep, ne);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule